// File: doc/BRIEF.md
# SMBus Clock Output Enable Controller

This block sits beside a single-input, many-output clock fan-out stage. It listens on a two-wire SMBus as a write-only slave. It keeps one enable bit per true/complement output pair and one enable bit for a feedback output, and it gates each output with its enable bit. A disabled pair holds both pins low. An active-low power-down input forces every output low, whatever the enable bits hold.

A mode input picks how the complement pins behave. In the high mode, every pair drives a true copy and an inverted copy of the reference clock. In the low mode, the lower pairs drive the reference clock on both pins, and the upper pairs stay true/complement. The bus lines are sampled with the system clock. The controller acknowledges by pulling the data line low through an open-drain enable. Written values take effect only when a STOP condition closes the frame.

Top module: `cfo_clk_enable_ctl`

## Requirements
- R1: After reset, every pair and the feedback output are enabled, so each true pin and the feedback pin copy the reference clock before any bus write.
- R2: A frame whose first byte is 8'hD2 (address 7'h69, write bit 0) is acknowledged on that byte and on every later byte of the frame. The acknowledge pulls the data line low only during the acknowledge bit, and the pull starts while the clock line is low.
- R3: A frame whose first byte carries another address, or the address with the read bit set (8'hD3), gets no acknowledge on any of its bytes and changes no enable.
- R4: A write frame is address, command code, byte count, then data bytes, and data byte k goes to register k. The command code and the byte count do not steer the data. Registers 0 to 5 and all data bytes past register 7 are acknowledged and have no effect. A frame that ends before register 7 leaves the register 7 enables unchanged.
- R5: In register 7, bit i enables pair i, for i from 0 to 7. A value of 1 means active.
- R6: In register 6, bits 3..0 enable pairs 11..8 and bit 4 enables the feedback output. Bits 7..5 have no effect.
- R7: A disabled pair holds both of its pins low while the reference clock toggles.
- R8: Enables change only on a STOP condition. A repeated START throws away the data bytes staged so far in the frame.
- R9: While the power-down input is 0, every true pin, every complement pin and the feedback pin is low.
- R10: With mode input 1, every enabled pair drives the reference clock on its true pin and the inverted reference clock on its complement pin.
- R11: With mode input 0, enabled pairs 0 to 5 drive the reference clock on both pins, and enabled pairs 6 to 11 stay true/complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SMBus clock line |
| sda_i | input | 1 | SMBus data line as seen on the wire |
| sda_pull_o | output | 1 | Open-drain enable; 1 pulls the data line low to acknowledge |
| ref_clk_i | input | 1 | Reference clock that is fanned out |
| pwr_dn_n_i | input | 1 | Active-low power-down; 0 forces all outputs low |
| mode_ddr_i | input | 1 | 1: all pairs true/complement; 0: lower pairs carry two true copies |
| clk_t_o | output | NUM_PAIRS | True pin of each output pair |
| clk_c_o | output | NUM_PAIRS | Complement pin of each output pair |
| fb_clk_o | output | 1 | Feedback clock output |

## Verification
The hardest case to reach from the ports is a frame that has already staged fresh values for both enable registers but is then cut off. A plain STOP would commit those values, so the stimulus sends a complete, acknowledged write of all-zero enables and follows it with a repeated START to a foreign address before the STOP. The outputs must keep the old enables. Frames that carry bytes past register 7, or that stop before reaching it, probe the byte-index mapping. A behavioural model of the expected pins is compared on every clock while the reference clock runs unrelated to the sampling clock.

// File: rtl/cfo_pkg.sv
package cfo_pkg;
   typedef enum logic [1:0] {
      RX_IDLE,
      RX_BITS,
      RX_ACK,
      RX_SKIP
   } rx_state_e;

   localparam int unsigned BYTE_W     = 8;
   localparam int unsigned HDR_BYTES  = 3;   // address, command, count
   localparam int unsigned REG_COUNT  = 8;
   localparam int unsigned IDX_HI_REG = 6;   // pairs 11..8 and feedback
   localparam int unsigned IDX_LO_REG = 7;   // pairs 7..0
   localparam int unsigned HI_BITS    = 5;   // live bits of register 6
   localparam int unsigned MAX_PAIRS  = 12;
   localparam int unsigned FB_BIT     = 12;  // feedback bit in packed map
endpackage

// File: rtl/cfo_sync.sv
module cfo_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   genvar b;
   for (b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
   end
endmodule

// File: rtl/cfo_smb_rx.sv
module cfo_smb_rx
   import cfo_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR = 7'h69,
   parameter int unsigned CNT_W    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   output logic              sda_pull,
   output logic              start_ev,
   output logic              stop_ev,
   output logic              wr_stb,
   output logic [CNT_W-1:0]  wr_idx,
   output logic [BYTE_W-1:0] wr_data
);
   localparam logic [BYTE_W-1:0] WR_ADDR = {DEV_ADDR, 1'b0};
   localparam logic [CNT_W-1:0]  HDR_N   = CNT_W'(HDR_BYTES);

   logic              scl_d, sda_d;
   logic              scl_rise, scl_fall;
   rx_state_e         state;
   logic [3:0]        bit_cnt;
   logic [CNT_W-1:0]  byte_cnt;
   logic [BYTE_W-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign scl_rise = scl_s & ~scl_d;
   assign scl_fall = ~scl_s & scl_d;
   assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RX_IDLE;
         bit_cnt  <= '0;
         byte_cnt <= '0;
         shreg    <= '0;
         sda_pull <= 1'b0;
         wr_stb   <= 1'b0;
         wr_idx   <= '0;
         wr_data  <= '0;
      end else begin
         wr_stb <= 1'b0;
         if (start_ev) begin
            state    <= RX_BITS;
            bit_cnt  <= '0;
            byte_cnt <= '0;
            sda_pull <= 1'b0;
         end else if (stop_ev) begin
            state    <= RX_IDLE;
            sda_pull <= 1'b0;
         end else begin
            unique case (state)
               RX_BITS: begin
                  if (scl_rise) begin
                     shreg   <= {shreg[BYTE_W-2:0], sda_s};
                     bit_cnt <= bit_cnt + 4'd1;
                  end else if (scl_fall && bit_cnt == 4'd8) begin
                     if (byte_cnt == '0 && shreg != WR_ADDR) begin
                        state <= RX_SKIP;
                     end else begin
                        state    <= RX_ACK;
                        sda_pull <= 1'b1;
                        if (byte_cnt >= HDR_N) begin
                           wr_stb  <= 1'b1;
                           wr_idx  <= byte_cnt - HDR_N;
                           wr_data <= shreg;
                        end
                     end
                  end
               end
               RX_ACK: begin
                  if (scl_fall) begin
                     sda_pull <= 1'b0;
                     state    <= RX_BITS;
                     bit_cnt  <= '0;
                     if (byte_cnt != '1) byte_cnt <= byte_cnt + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/cfo_regs.sv
module cfo_regs
   import cfo_pkg::*;
#(
   parameter int unsigned NUM_PAIRS = 12,
   parameter int unsigned CNT_W     = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_ev,
   input  logic                 stop_ev,
   input  logic                 wr_stb,
   input  logic [CNT_W-1:0]     wr_idx,
   input  logic [BYTE_W-1:0]    wr_data,
   output logic [NUM_PAIRS-1:0] en_pairs,
   output logic                 en_fb
);
   localparam logic [CNT_W-1:0] LO_IDX = CNT_W'(IDX_LO_REG);
   localparam logic [CNT_W-1:0] HI_IDX = CNT_W'(IDX_HI_REG);

   logic [BYTE_W-1:0]  cur_lo, stg_lo;
   logic [HI_BITS-1:0] cur_hi, stg_hi;
   logic               hit_lo, hit_hi;
   logic [BYTE_W+HI_BITS-1:0] en_all;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_lo <= '1;
         cur_hi <= '1;
         stg_lo <= '0;
         stg_hi <= '0;
         hit_lo <= 1'b0;
         hit_hi <= 1'b0;
      end else if (start_ev) begin
         hit_lo <= 1'b0;
         hit_hi <= 1'b0;
      end else if (stop_ev) begin
         if (hit_lo) cur_lo <= stg_lo;
         if (hit_hi) cur_hi <= stg_hi;
         hit_lo <= 1'b0;
         hit_hi <= 1'b0;
      end else if (wr_stb) begin
         if (wr_idx == LO_IDX) begin
            stg_lo <= wr_data;
            hit_lo <= 1'b1;
         end
         if (wr_idx == HI_IDX) begin
            stg_hi <= wr_data[HI_BITS-1:0];
            hit_hi <= 1'b1;
         end
      end
   end

   assign en_all   = {cur_hi, cur_lo};
   assign en_pairs = en_all[NUM_PAIRS-1:0];
   assign en_fb    = en_all[FB_BIT];
endmodule

// File: rtl/cfo_gate.sv
module cfo_gate #(
   parameter int unsigned NUM_PAIRS   = 12,
   parameter int unsigned SDRAM_PAIRS = 6
) (
   input  logic                 ref_clk,
   input  logic                 pwr_dn_n,
   input  logic                 mode_ddr,
   input  logic [NUM_PAIRS-1:0] en_pairs,
   input  logic                 en_fb,
   output logic [NUM_PAIRS-1:0] out_t,
   output logic [NUM_PAIRS-1:0] out_c,
   output logic                 fb_out
);
   genvar p;
   for (p = 0; p < NUM_PAIRS; p++) begin : g_pair
      logic live;
      assign live     = pwr_dn_n & en_pairs[p];
      assign out_t[p] = live & ref_clk;
      if (p < SDRAM_PAIRS) begin : g_dual
         assign out_c[p] = live & (mode_ddr ? ~ref_clk : ref_clk);
      end else begin : g_diff
         assign out_c[p] = live & ~ref_clk;
      end
   end
   assign fb_out = pwr_dn_n & en_fb & ref_clk;
endmodule

// File: rtl/cfo_clk_enable_ctl.sv
module cfo_clk_enable_ctl
   import cfo_pkg::*;
#(
   parameter int unsigned NUM_PAIRS   = 12,
   parameter int unsigned SDRAM_PAIRS = 6,
   parameter logic [6:0]  DEV_ADDR    = 7'h69,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 scl_i,
   input  logic                 sda_i,
   output logic                 sda_pull_o,
   input  logic                 ref_clk_i,
   input  logic                 pwr_dn_n_i,
   input  logic                 mode_ddr_i,
   output logic [NUM_PAIRS-1:0] clk_t_o,
   output logic [NUM_PAIRS-1:0] clk_c_o,
   output logic                 fb_clk_o
);
   localparam int unsigned CNT_W = $clog2(HDR_BYTES + REG_COUNT) + 1;

   if (NUM_PAIRS < 1 || NUM_PAIRS > MAX_PAIRS) begin : g_bad_pairs
      $error("NUM_PAIRS out of range");
   end
   if (SDRAM_PAIRS > NUM_PAIRS) begin : g_bad_sdram
      $error("SDRAM_PAIRS exceeds NUM_PAIRS");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic scl_s, sda_s;
   logic start_ev, stop_ev, wr_stb;
   logic [CNT_W-1:0]     wr_idx;
   logic [BYTE_W-1:0]    wr_data;
   logic [NUM_PAIRS-1:0] en_pairs;
   logic                 en_fb;

   cfo_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) sync_i (
      .clk (clk),
      .rst_n (rst_n),
      .d ({scl_i, sda_i}),
      .q ({scl_s, sda_s})
   );

   cfo_smb_rx #(.DEV_ADDR(DEV_ADDR), .CNT_W(CNT_W)) rx_i (
      .clk (clk),
      .rst_n (rst_n),
      .scl_s (scl_s),
      .sda_s (sda_s),
      .sda_pull (sda_pull_o),
      .start_ev (start_ev),
      .stop_ev (stop_ev),
      .wr_stb (wr_stb),
      .wr_idx (wr_idx),
      .wr_data (wr_data)
   );

   cfo_regs #(.NUM_PAIRS(NUM_PAIRS), .CNT_W(CNT_W)) regs_i (
      .clk (clk),
      .rst_n (rst_n),
      .start_ev (start_ev),
      .stop_ev (stop_ev),
      .wr_stb (wr_stb),
      .wr_idx (wr_idx),
      .wr_data (wr_data),
      .en_pairs (en_pairs),
      .en_fb (en_fb)
   );

   cfo_gate #(.NUM_PAIRS(NUM_PAIRS), .SDRAM_PAIRS(SDRAM_PAIRS)) gate_i (
      .ref_clk (ref_clk_i),
      .pwr_dn_n (pwr_dn_n_i),
      .mode_ddr (mode_ddr_i),
      .en_pairs (en_pairs),
      .en_fb (en_fb),
      .out_t (clk_t_o),
      .out_c (clk_c_o),
      .fb_out (fb_clk_o)
   );
endmodule

// File: rtl/cfo_clk_enable_chk.sv
module cfo_clk_enable_chk #(
   parameter int unsigned NUM_PAIRS   = 12,
   parameter int unsigned SDRAM_PAIRS = 6
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 scl_s,
   input logic                 stop_ev,
   input logic                 sda_pull,
   input logic                 pwr_dn_n,
   input logic                 mode_ddr,
   input logic [NUM_PAIRS-1:0] en_pairs,
   input logic                 en_fb,
   input logic [NUM_PAIRS-1:0] out_t,
   input logic [NUM_PAIRS-1:0] out_c,
   input logic                 fb
);
   localparam logic [NUM_PAIRS-1:0] UPPER = {NUM_PAIRS{1'b1}} << SDRAM_PAIRS;

   a_r2_ack_starts_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull) |-> !scl_s);

   a_r8_commit_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(stop_ev) |-> ($stable(en_pairs) && $stable(en_fb)));

   a_r9_pdn_all_low: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_dn_n |-> (out_t == '0 && out_c == '0 && !fb));

   a_r7_off_pair_low: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_dn_n |-> (((out_t | out_c) & ~en_pairs) == '0));

   a_r10_ddr_complement: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_dn_n && mode_ddr) |-> ((out_t ^ out_c) == en_pairs));

   a_r11_sdram_lower_true: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_dn_n && !mode_ddr) |-> ((out_t ^ out_c) == (en_pairs & UPPER)));
endmodule

bind cfo_clk_enable_ctl cfo_clk_enable_chk #(
   .NUM_PAIRS (NUM_PAIRS),
   .SDRAM_PAIRS (SDRAM_PAIRS)
) chk_i (
   .clk (clk),
   .rst_n (rst_n),
   .scl_s (scl_s),
   .stop_ev (stop_ev),
   .sda_pull (sda_pull_o),
   .pwr_dn_n (pwr_dn_n_i),
   .mode_ddr (mode_ddr_i),
   .en_pairs (en_pairs),
   .en_fb (en_fb),
   .out_t (clk_t_o),
   .out_c (clk_c_o),
   .fb (fb_clk_o)
);

// File: tb/cfo_clk_enable_ctl_tb_top.sv
`timescale 1ns/1ps
module cfo_clk_enable_ctl_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic refc = 1'b0;
   logic pdn = 1'b1;
   logic ddr = 1'b1;
   logic sda_pull;
   logic sda_line;
   logic [11:0] clk_t, clk_c;
   logic fb;

   int n_checks = 0;
   int n_err = 0;
   bit cmp_on = 0;
   bit settle = 0;
   logic [12:0] m_en = '1;
   logic [7:0] frame[$];

   always #2 clk = ~clk;
   initial begin
      #1;
      forever #4 refc = ~refc;
   end

   assign sda_line = sda_m & ~sda_pull;

   cfo_clk_enable_ctl dut_i (
      .clk (clk),
      .rst_n (rst_n),
      .scl_i (scl_m),
      .sda_i (sda_line),
      .sda_pull_o (sda_pull),
      .ref_clk_i (refc),
      .pwr_dn_n_i (pdn),
      .mode_ddr_i (ddr),
      .clk_t_o (clk_t),
      .clk_c_o (clk_c),
      .fb_clk_o (fb)
   );

   task automatic cmp_pins(input string tag);
      logic [11:0] et, ec;
      logic ef;
      for (int p = 0; p < 12; p++) begin
         et[p] = pdn & m_en[p] & refc;
         ec[p] = pdn & m_en[p] & ((ddr || p >= 6) ? ~refc : refc);
      end
      ef = pdn & m_en[12] & refc;
      n_checks++;
      if (clk_t !== et || clk_c !== ec || fb !== ef) begin
         n_err++;
         $display("FAIL %s: t=%h c=%h fb=%b expected t=%h c=%h fb=%b",
                  tag, clk_t, clk_c, fb, et, ec, ef);
      end
   endtask

   // per-cycle comparison against the behavioural model (R7 R9 R10 R11)
   always @(negedge clk) begin
      if (cmp_on && !settle) cmp_pins("R7 R9 R10 R11 cycle");
   end

   task automatic check_state(input string tag);
      for (int i = 0; i < 2; i++) begin
         @(negedge clk);
         cmp_pins(tag);
      end
   endtask

   task automatic hp();
      repeat (6) @(posedge clk);
      #1;
   endtask

   task automatic smb_start();
      sda_m = 1'b1; hp();
      scl_m = 1'b1; hp();
      sda_m = 1'b0; hp();
      scl_m = 1'b0; hp();
      frame.delete();
   endtask

   task automatic smb_stop();
      settle = 1;
      sda_m = 1'b0; hp();
      scl_m = 1'b1; hp();
      sda_m = 1'b1; hp();
      if (frame.size() > 0 && frame[0] == 8'hD2) begin
         for (int k = 3; k < frame.size(); k++) begin
            if (k - 3 == 7) m_en[7:0]  = frame[k];
            if (k - 3 == 6) m_en[12:8] = frame[k][4:0];
         end
      end
      frame.delete();
      settle = 0;
   endtask

   task automatic send_byte(input logic [7:0] b);
      logic exp_ack, got_ack;
      exp_ack = (frame.size() == 0) ? (b == 8'hD2) : (frame[0] == 8'hD2);
      frame.push_back(b);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; hp();
         scl_m = 1'b1; hp();
         scl_m = 1'b0;
      end
      sda_m = 1'b1; hp();
      scl_m = 1'b1; hp();
      got_ack = ~sda_line;
      scl_m = 1'b0; hp();
      n_checks++;
      if (got_ack !== exp_ack) begin
         n_err++;
         $display("FAIL %s: ack=%b expected ack=%b on byte %h",
                  exp_ack ? "R2" : "R3", got_ack, exp_ack, b);
      end
   endtask

   task automatic write_body(input logic [7:0] r6, input logic [7:0] r7, input int ndata);
      send_byte(8'hD2);
      send_byte(8'h00);
      send_byte(8'(ndata));
      for (int k = 0; k < ndata; k++) begin
         if (k == 6)      send_byte(r6);
         else if (k == 7) send_byte(r7);
         else if (k < 6)  send_byte(8'(8'h11 * k));
         else             send_byte(8'h00);
      end
   endtask

   task automatic write_regs(input logic [7:0] r6, input logic [7:0] r7, input int ndata);
      smb_start();
      write_body(r6, r7, ndata);
      smb_stop();
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL R2: watchdog expired, actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (4) @(posedge clk);
      #1 cmp_on = 1;
      // R1: all outputs on after reset
      check_state("R1");

      // R3: foreign address, then read request
      smb_start();
      send_byte(8'hA4); send_byte(8'h00); send_byte(8'h08);
      for (int k = 0; k < 8; k++) send_byte(8'h00);
      smb_stop();
      check_state("R3");
      smb_start(); send_byte(8'hD3); send_byte(8'h00); smb_stop();
      check_state("R3");

      // R5 R6: pattern in both registers, reserved bits set
      write_regs(8'hEA, 8'hA5, 8);
      check_state("R5");
      check_state("R6");

      // R4: extra bytes past register 7 ignored
      write_regs(8'hF3, 8'h3C, 11);
      check_state("R4");
      // R4: frame ending at register 6 keeps register 7
      write_regs(8'h05, 8'h00, 7);
      check_state("R4");

      // R8: staged zeros discarded by repeated START
      smb_start();
      write_body(8'h00, 8'h00, 8);
      smb_start();
      send_byte(8'hA4);
      smb_stop();
      check_state("R8");

      // R7: everything disabled
      write_regs(8'h00, 8'h00, 8);
      check_state("R7");

      // R11 / R10: mode select with mixed enables
      write_regs(8'h1B, 8'hE5, 8);
      #1 ddr = 1'b0;
      check_state("R11");
      #1 ddr = 1'b1;
      check_state("R10");

      // R9: power-down overrides, then a full restore
      #1 pdn = 1'b0;
      check_state("R9");
      write_regs(8'h1F, 8'hFF, 8);
      check_state("R9");
      #1 pdn = 1'b1;
      check_state("R5");

      repeat (10) @(posedge clk);
      finish_run();
   end
endmodule